// File: doc/BRIEF.md
# Coincident-Selection Static Memory

This block is a parameterized static memory. To the outside it is a flat array of `WORDS` entries, each `WIDTH` bits wide, reached through one address bus, one write-data bus and one tri-state read-data bus. It has no clock. A chip-enable gates every access. A single read/write-select line picks between reading (1) and writing (0).

Internally the words sit in a grid of `ROWS = WORDS / COLS` rows by `COLS` columns. The low address bits go to a row decoder. The high address bits go to a column decoder, and chip-enable gates that column decoder. Each column is a group of `WIDTH` bitslices, and each bitslice is a vertical stack of `ROWS` storage cells. A cell is a level-sensitive latch. It is selected only where its row line and its bitslice line are both active. When `COLS` is 1 the column decoder disappears and chip-enable drives the single column directly. When `COLS` equals `WORDS` the row decoder disappears and every bitslice holds a single cell.

`WORDS`, `WIDTH` and `COLS` must be powers of two, with `WORDS` at least 2 and `COLS` no larger than `WORDS`. Any other combination stops elaboration with an error.

Top module: `sram_grid`

## Requirements
- R1: With `mem_en`=1 and `rd_wrn`=1, `rd_data` shows the word most recently written at `addr`.
- R2: While a write is enabled (`mem_en`=1, `rd_wrn`=0), every bit of `rd_data` is high-impedance.
- R3: With `mem_en`=0, every bit of `rd_data` is high-impedance. No column is selected, and no stored word changes whatever `addr`, `wr_data` and `rd_wrn` do.
- R4: The row index is `addr[ROW_W-1:0]` and the column index is `addr[ADDR_W-1:ROW_W]`, so the word at column c, row r has address c*ROWS+r. For 16 words in 4 columns, address 6 lies at row 2, column 1. A read selects exactly the cells of the addressed word.
- R5: Exactly one row select is active at all times. Exactly one column select is active while `mem_en`=1.
- R6: At most one cell drives any data-out line at a time.
- R7: For any legal `COLS`, every write/read sequence gives the same `rd_data` as the same sequence on a one-column build.
- R8: Writing is level-sensitive. If `wr_data` changes while a write stays enabled, the word keeps the last value present before the enable falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | ADDR_W = log2(WORDS) | Word address. The low bits select the row and the high bits select the column. |
| wr_data | input | WIDTH | Data written into the addressed word. |
| rd_data | output | WIDTH | Read data. High-impedance unless a read is enabled. |
| mem_en | input | 1 | Chip enable. It gates the column decoder. |
| rd_wrn | input | 1 | Access direction: 1 reads, 0 writes. |

## Verification
The bench first fills every address with its own inverted value and reads all of them back. Because every address holds a different value, any crossing of row bits and column bits shows up as a mismatch. Constrained-random mixes of writes and reads then run on builds with 1, 4 and 16 columns, all compared with a flat reference array. This separates a correct grid mapping from one that only looks correct for a particular shape.

Directed cases cover the following:
- Writes attempted with the enable low, which must leave the stored word untouched.
- Write data that changes mid-write, which tells a latch apart from an edge-captured store.
- Idle and write phases, where a pull-up bus and a pull-down bus must split apart. This proves that nothing drives the output.

// File: rtl/sram_grid_pkg.sv
// Shared helpers for the coincident-selection memory.
// Assumes: callers pass non-negative integers.
package sram_grid_pkg;

    // Returns 1 when v is a positive power of two.
    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/sram_grid_decoder.sv
// Binary-to-one-hot decoder with an enable.
// Output bit i is 1 only when en is 1 and sel equals i. All outputs are 0 when en is 0.
// Assumes: SEL_W >= 1. The parent handles the zero-width case itself.
module sram_grid_decoder #(
    parameter int SEL_W = 2,
    localparam int OUTS = 1 << SEL_W
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [OUTS-1:0]  hot
);

    // Set the single line named by sel, gated by en.
    always_comb begin
        hot = '0;
        for (int i = 0; i < OUTS; i++) begin
            if (en && (sel == SEL_W'(i))) begin
                hot[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sram_grid_cell.sv
// One storage bit: a level-sensitive latch with two select inputs.
// The latch is transparent while both selects are 1 and a write is requested.
// The cell requests the read line only while both selects are 1 and a read is requested.
// Assumes: the parent resolves the cells' read requests onto one shared line.
module sram_grid_cell (
    input  logic row_sel,
    input  logic slice_sel,
    input  logic rd_wrn,
    input  logic d,
    output logic drive_en,
    output logic drive_val
);

    logic picked;
    logic store;

    assign picked = row_sel & slice_sel;

    // Storage latch: follows d while the cell is write-enabled.
    always_latch begin
        if (picked && !rd_wrn) begin
            store <= d;
        end
    end

    // Read request and the value this cell puts on the line.
    always_comb begin
        drive_en  = picked & rd_wrn;
        drive_val = drive_en & store;
    end

endmodule

// File: rtl/sram_grid_bitslice.sv
// A vertical stack of ROWS cells that share one write-data bit, one bitslice select
// and one read line. The row selects choose a single cell inside the stack.
// Assumes: row_sel is one-hot, so at most one cell drives the line.
module sram_grid_bitslice #(
    parameter int ROWS = 4
) (
    input  logic [ROWS-1:0] row_sel,
    input  logic            slice_sel,
    input  logic            rd_wrn,
    input  logic            d,
    output logic [ROWS-1:0] cell_drv,
    output logic            line
);

    logic [ROWS-1:0] cell_val;

    // One cell per row.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        sram_grid_cell u_cell (
            .row_sel   (row_sel[r]),
            .slice_sel (slice_sel),
            .rd_wrn    (rd_wrn),
            .d         (d),
            .drive_en  (cell_drv[r]),
            .drive_val (cell_val[r])
        );
    end

    // Wired-OR of the cell contributions onto the shared read line.
    assign line = |cell_val;

endmodule

// File: rtl/sram_grid.sv
// Coincident-selection static memory: WORDS x WIDTH bits laid out as a grid of
// ROWS x COLS words.
// The low address bits pick the row. The high address bits, gated by mem_en, pick the column.
// Each column holds WIDTH bitslices.
// Assumes: WORDS, WIDTH and COLS are powers of two, WORDS >= 2 and COLS <= WORDS.
module sram_grid
    import sram_grid_pkg::*;
#(
    parameter int WORDS = 16,
    parameter int WIDTH = 4,
    parameter int COLS  = 4,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  rd_data,
    input  logic              mem_en,
    input  logic              rd_wrn
);

    localparam int COL_W = $clog2(COLS);
    localparam int ROW_W = ADDR_W - COL_W;
    localparam int ROWS  = WORDS / COLS;

    // Parameter guard: stop elaboration on an illegal shape.
    if (!is_pow2(WORDS) || WORDS < 2 || !is_pow2(WIDTH) || !is_pow2(COLS) || COLS > WORDS) begin : g_bad_shape
        $error("sram_grid: illegal WORDS/WIDTH/COLS combination");
    end

    logic [ROWS-1:0]              row_sel;
    logic [COLS-1:0]              col_sel;
    logic [WIDTH-1:0][WORDS-1:0]  drv_en;
    logic [WIDTH-1:0][COLS-1:0]   col_line;

    // Row decoder: a single row when every word has its own column.
    if (ROW_W == 0) begin : g_row_none
        assign row_sel = 1'b1;
    end else begin : g_row_dec
        sram_grid_decoder #(.SEL_W(ROW_W)) u_row_dec (
            .en  (1'b1),
            .sel (addr[ROW_W-1:0]),
            .hot (row_sel)
        );
    end

    // Column decoder: mem_en drives the single column directly when COLS is 1.
    if (COL_W == 0) begin : g_col_none
        assign col_sel = mem_en;
    end else begin : g_col_dec
        sram_grid_decoder #(.SEL_W(COL_W)) u_col_dec (
            .en  (mem_en),
            .sel (addr[ADDR_W-1:ROW_W]),
            .hot (col_sel)
        );
    end

    // Bitslice array: one slice per data bit in every column.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            sram_grid_bitslice #(.ROWS(ROWS)) u_slice (
                .row_sel   (row_sel),
                .slice_sel (col_sel[c]),
                .rd_wrn    (rd_wrn),
                .d         (wr_data[b]),
                .cell_drv  (drv_en[b][c*ROWS +: ROWS]),
                .line      (col_line[b][c])
            );
        end
    end

    // Output buffers: a bit is driven only while some cell requests it.
    for (genvar b = 0; b < WIDTH; b++) begin : g_out
        assign rd_data[b] = (|drv_en[b]) ? (|col_line[b]) : 1'bz;
    end

endmodule

// File: rtl/sram_grid_chk.sv
// Checker for sram_grid, attached through bind.
// It watches the decoder outputs and the per-cell read requests against the ports.
// Assumes: the same parameters as the bound instance.
module sram_grid_chk #(
    parameter int WORDS = 16,
    parameter int WIDTH = 4,
    parameter int COLS  = 4,
    localparam int ADDR_W = $clog2(WORDS),
    localparam int ROWS   = WORDS / COLS
) (
    input logic [ADDR_W-1:0]            addr,
    input logic                         mem_en,
    input logic                         rd_wrn,
    input logic [ROWS-1:0]              row_sel,
    input logic [COLS-1:0]              col_sel,
    input logic [WIDTH-1:0][WORDS-1:0]  drv_en
);

    // Selection and drive rules, re-evaluated whenever an input moves.
    always_comb begin
        AST_ROW_ONEHOT: assert ($onehot(row_sel)) else $error("row select not one-hot"); // R5
        if (mem_en) begin
            AST_COL_ONEHOT: assert ($onehot(col_sel)) else $error("column select not one-hot"); // R5
        end else begin
            AST_COL_IDLE: assert (col_sel == '0) else $error("column selected while disabled"); // R3
        end
        for (int b = 0; b < WIDTH; b++) begin
            AST_LINE_ONE_DRIVER: assert ($onehot0(drv_en[b])) else $error("contention on a read line"); // R6
            if (mem_en && rd_wrn) begin
                AST_DRIVE_ADDRESSED: assert (drv_en[b][addr]) else $error("addressed cell not driving"); // R4
            end else begin
                AST_NO_DRIVE_IDLE: assert (drv_en[b] == '0) else $error("cell drives outside a read"); // R2
            end
        end
    end

endmodule

bind sram_grid sram_grid_chk #(
    .WORDS (WORDS),
    .WIDTH (WIDTH),
    .COLS  (COLS)
) u_chk (
    .addr    (addr),
    .mem_en  (mem_en),
    .rd_wrn  (rd_wrn),
    .row_sel (row_sel),
    .col_sel (col_sel),
    .drv_en  (drv_en)
);

// File: tb/sram_grid_test.sv
// Bench for sram_grid.
// Four builds share one stimulus: COLS = 4 (twice, once on a pull-up bus and once on a
// pull-down bus), COLS = 1 and COLS = 16. A flat reference array supplies the expected words.
// A high-impedance output reads as 1 on the pull-up bus and as 0 on the pull-down bus.
module sram_grid_test;

    localparam int WORDS = 16;
    localparam int WIDTH = 4;
    localparam int AW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic [WIDTH-1:0] wdat = '0;
    logic             en = 1'b0;
    logic             rdw = 1'b1;

    wire [WIDTH-1:0] bus_pu;
    wire [WIDTH-1:0] bus_pd;
    wire [WIDTH-1:0] bus_flat;
    wire [WIDTH-1:0] bus_wide;

    logic [WIDTH-1:0] ref_mem [WORDS];
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pull
        pullup   (bus_pu[i]);
        pulldown (bus_pd[i]);
        pulldown (bus_flat[i]);
        pulldown (bus_wide[i]);
    end

    sram_grid #(.WORDS(WORDS), .WIDTH(WIDTH), .COLS(4)) uut (
        .addr(addr), .wr_data(wdat), .rd_data(bus_pu), .mem_en(en), .rd_wrn(rdw));
    sram_grid #(.WORDS(WORDS), .WIDTH(WIDTH), .COLS(4)) uut_pd (
        .addr(addr), .wr_data(wdat), .rd_data(bus_pd), .mem_en(en), .rd_wrn(rdw));
    sram_grid #(.WORDS(WORDS), .WIDTH(WIDTH), .COLS(1)) uut_flat (
        .addr(addr), .wr_data(wdat), .rd_data(bus_flat), .mem_en(en), .rd_wrn(rdw));
    sram_grid #(.WORDS(WORDS), .WIDTH(WIDTH), .COLS(16)) uut_wide (
        .addr(addr), .wr_data(wdat), .rd_data(bus_wide), .mem_en(en), .rd_wrn(rdw));

    // Compare one value and count the result.
    task automatic chk(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // The output is undriven when the pull-up and pull-down buses split to all-1 and all-0.
    task automatic chk_hiz(input string req);
        chk(req, bus_pu, '1);
        chk(req, bus_pd, '0);
    endtask

    // Write one word. R2: the output stays undriven during the enabled phase.
    task automatic do_write(input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
        @(negedge clk); addr = a; wdat = d; rdw = 1'b0; en = 1'b0;
        @(negedge clk); en = 1'b1;
        @(posedge clk); #1; chk_hiz("R2 write phase");
        @(negedge clk); en = 1'b0;
        ref_mem[a] = d;
    endtask

    // Read one word from every build and compare each with the reference (R1, R7).
    task automatic do_read(input logic [AW-1:0] a);
        @(negedge clk); addr = a; rdw = 1'b1; en = 1'b1;
        @(posedge clk); #1;
        chk("R1 read COLS=4", bus_pu, ref_mem[a]);
        chk("R1 read COLS=4 pd", bus_pd, ref_mem[a]);
        chk("R7 read COLS=1", bus_flat, ref_mem[a]);
        chk("R7 read COLS=16", bus_wide, ref_mem[a]);
        @(negedge clk); en = 1'b0;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        void'($urandom(32'h0000_5eed));
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        #1;
        chk_hiz("R3 reset idle");

        // R4: every address gets a distinct value, so a mis-decoded address shows up on read-back.
        for (int a = 0; a < WORDS; a++) do_write(AW'(a), ~WIDTH'(a));
        for (int a = 0; a < WORDS; a++) do_read(AW'(a));
        // R4: address 6 is row 2, column 1 in the four-column build.
        do_write(4'd6, 4'hA);
        do_read(4'd6);
        do_read(4'd2);
        do_read(4'd14);

        // R3: write strobes with the enable low leave the word unchanged.
        @(negedge clk); addr = 4'd3; wdat = 4'h5; rdw = 1'b0; en = 1'b0;
        @(posedge clk); #1; chk_hiz("R3 disabled write");
        @(negedge clk); addr = 4'd7; wdat = 4'hF;
        @(posedge clk); #1; chk_hiz("R3 disabled write addr change");
        do_read(4'd3);
        do_read(4'd7);
        // R3: a read request with the enable low drives nothing.
        @(negedge clk); addr = 4'd3; rdw = 1'b1; en = 1'b0;
        @(posedge clk); #1; chk_hiz("R3 disabled read");

        // R8: the latch follows the data while the write stays open and keeps the last value.
        @(negedge clk); addr = 4'd9; wdat = 4'h1; rdw = 1'b0; en = 1'b0;
        @(negedge clk); en = 1'b1;
        @(negedge clk); wdat = 4'hC;
        @(posedge clk); #1; chk_hiz("R2 open write");
        @(negedge clk); en = 1'b0;
        ref_mem[9] = 4'hC;
        do_read(4'd9);

        // R1: back-to-back writes to one address; the last write wins.
        do_write(4'd0, 4'h3);
        do_write(4'd0, 4'h8);
        do_read(4'd0);
        do_write(4'd15, 4'h0);
        do_read(4'd15);

        // R1, R7: constrained-random mix, roughly 60% reads.
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom_range(WORDS - 1, 0));
            if ($urandom_range(9, 0) < 4) do_write(ra, WIDTH'($urandom));
            else do_read(ra);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule